// File: doc/BRIEF.md
# USB Device Endpoint Buffer Ready Tracker

This block tracks buffer readiness for six transmit and six receive endpoints of a USB device controller. Software places prime requests and flush requests through a small word-addressed register bus and reads back a read-only ready register. Pending primes are offered one at a time to the DMA side, which acknowledges them; each acknowledgement marks the matching buffer ready one cycle later.

A flush discards the ready state and any pending prime of an endpoint direction. It waits while the DMA side reports a packet in flight on that channel, and the flush bit drops by itself once the flush is done. The DMA side can also retire a buffer, which clears its ready bit, or re-prime it, which drops the ready bit for exactly one cycle before raising it again. A USB bus reset wipes all state and overrides every other source.

Top module: `ep_buffer_ctrl`

## Requirements
- R1: After reset the pending-prime, flush and ready registers are all zero, `prime_sel` is zero and `reg_rdata` is zero.
- R2: The prime register is at offset 0x1B0, flush at 0x1B4 and ready at 0x1B8. In each, bit 16+n is the transmit channel of endpoint n and bit n is its receive channel (n = 0..5). All other bits read as zero and ignore writes.
- R3: A write to the prime register sets the pending bit of every channel written as one. Writing zero changes nothing. A pending bit stays set until it is acknowledged or flushed.
- R4: `prime_sel` is one-hot or zero and marks the pending channel of highest priority. Priority is lowest endpoint first, and transmit before receive within an endpoint. The DMA-side vectors (`prime_sel`, `dma_busy`, `dma_retire`, `dma_reprime`) use bit n for the receive channel of endpoint n and bit 6+n for the transmit channel.
- R5: `prime_ack` high at a clock edge acknowledges the channel on `prime_sel`. That channel's ready bit is set and its pending bit cleared at that edge. A ready bit is never set at the same edge as the prime write that requests it.
- R6: A flush write sets the flush bit of every channel written as one. When a flush bit is set and the channel's busy bit is low, the flush bit, ready bit and pending prime of that channel are all cleared at the next edge.
- R7: While a channel's busy bit is high, its flush bit and ready bit are held unchanged by the flush.
- R8: `dma_retire` high on a channel clears its ready bit at that edge.
- R9: `dma_reprime` high on a channel clears its ready bit at that edge and sets it again at the following edge.
- R10: If a flush completes at the same edge as a prime acknowledge on one channel, the flush wins: the ready bit and the pending bit both end cleared.
- R11: `bus_reset` high at an edge clears all pending, flush and ready bits and overrides register writes and DMA events at that edge.
- R12: Writes to the ready register and to unmapped offsets have no effect. A read returns the addressed register on `reg_rdata` one cycle after `reg_rd`. Unmapped offsets read zero, and `reg_rdata` is zero in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | USB bus reset seen on the line |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the read strobe |
| prime_sel | output | 12 | One-hot channel offered for priming |
| prime_ack | input | 1 | DMA accepts the offered prime |
| dma_busy | input | 12 | Packet in flight per channel |
| dma_retire | input | 12 | Buffer retired per channel |
| dma_reprime | input | 12 | Hardware re-prime per channel |

## Verification
Register writes and DMA events land at the clock edge they are presented on. Ready, pending and flush bits therefore change at that edge, and a read issued in the next cycle sees the new value one edge later still. `prime_sel` is combinational from the pending bits and is valid in the cycle after a prime write. A re-prime shows ready low in the cycle after the event and high one cycle later. The bench drives every input at a falling edge and samples at the next falling edge, so each result is read exactly one edge after the stimulus or read strobe that produced it.

// File: rtl/ep_buf_pkg.sv
package ep_buf_pkg;
    localparam int NUM_EP   = 6;
    localparam int NUM_CH   = 2 * NUM_EP;
    localparam int TX_LSB   = 16;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam logic [ADDR_W-1:0] PRIME_OFF = 12'h1B0;
    localparam logic [ADDR_W-1:0] FLUSH_OFF = 12'h1B4;
    localparam logic [ADDR_W-1:0] READY_OFF = 12'h1B8;

    // channel vector: [NUM_EP-1:0] receive, [NUM_CH-1:NUM_EP] transmit
    typedef logic [NUM_CH-1:0] ch_vec_t;

    typedef struct packed {
        ch_vec_t prime;
        ch_vec_t flush;
        ch_vec_t ready;
        ch_vec_t reprime;
    } ep_state_t;

    function automatic ch_vec_t reg_to_ch(input logic [DATA_W-1:0] w);
        return {w[TX_LSB +: NUM_EP], w[0 +: NUM_EP]};
    endfunction

    function automatic logic [DATA_W-1:0] ch_to_reg(input ch_vec_t c);
        logic [DATA_W-1:0] r;
        r = '0;
        r[TX_LSB +: NUM_EP] = c[NUM_CH-1:NUM_EP];
        r[0 +: NUM_EP]      = c[NUM_EP-1:0];
        return r;
    endfunction
endpackage

// File: rtl/ep_reg_decode.sv
module ep_reg_decode
    import ep_buf_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  ch_vec_t       prime_view,
    input  ch_vec_t       flush_view,
    input  ch_vec_t       ready_view,
    output ch_vec_t       prime_set,
    output ch_vec_t       flush_set,
    output logic [DW-1:0] reg_rdata
);
    logic [DW-1:0] rdata_d, rdata_q;

    always_comb begin
        prime_set = '0;
        flush_set = '0;
        if (reg_wr && reg_addr == PRIME_OFF) prime_set = reg_to_ch(reg_wdata);
        if (reg_wr && reg_addr == FLUSH_OFF) flush_set = reg_to_ch(reg_wdata);
        rdata_d = '0;
        if (reg_rd) begin
            case (reg_addr)
                PRIME_OFF: rdata_d = ch_to_reg(prime_view);
                FLUSH_OFF: rdata_d = ch_to_reg(flush_view);
                READY_OFF: rdata_d = ch_to_reg(ready_view);
                default:   rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign reg_rdata = rdata_q;

    // R12: no read strobe, no data next cycle
    p_idle_rdata_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> (reg_rdata == '0));
endmodule

// File: rtl/ep_prime_arb.sv
module ep_prime_arb
    import ep_buf_pkg::*;
#(
    parameter int EPS = NUM_EP
) (
    input  logic    clk,
    input  logic    rst_n,
    input  ch_vec_t pending,
    output ch_vec_t grant
);
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int n = 0; n < EPS; n++) begin
            if (!found && pending[EPS + n]) begin
                grant[EPS + n] = 1'b1;
                found = 1'b1;
            end
            if (!found && pending[n]) begin
                grant[n] = 1'b1;
                found = 1'b1;
            end
        end
    end

    p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    p_grant_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|pending) |-> ((grant & ~pending) == '0) && (grant != '0));
endmodule

// File: rtl/ep_ready_track.sv
module ep_ready_track
    import ep_buf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    bus_reset,
    input  ch_vec_t prime_set,
    input  ch_vec_t flush_set,
    input  ch_vec_t grant,
    input  logic    prime_ack,
    input  ch_vec_t dma_busy,
    input  ch_vec_t dma_retire,
    input  ch_vec_t dma_reprime,
    output ch_vec_t prime_q,
    output ch_vec_t flush_q,
    output ch_vec_t ready_q
);
    ep_state_t st_d, st_q;
    ch_vec_t   ack_hit, flush_done;

    always_comb begin
        ack_hit    = grant & {NUM_CH{prime_ack}};
        flush_done = st_q.flush & ~dma_busy;
        st_d       = st_q;
        if (bus_reset) begin
            st_d = '0;
        end else begin
            st_d.prime   = (st_q.prime & ~ack_hit & ~flush_done) | prime_set;
            st_d.flush   = (st_q.flush & ~flush_done) | flush_set;
            st_d.reprime = dma_reprime & ~flush_done;
            st_d.ready   = (st_q.ready | ack_hit | st_q.reprime)
                           & ~dma_retire & ~dma_reprime & ~flush_done;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prime_q = st_q.prime;
    assign flush_q = st_q.flush;
    assign ready_q = st_q.ready;

    // R11: bus reset wipes everything
    p_bus_reset_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (prime_q == '0) && (flush_q == '0) && (ready_q == '0));
    // R5: a ready bit rises only after an acknowledge or a re-prime
    p_ready_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_q & ~$past(ready_q) & ~$past(ack_hit | st_q.reprime)) == '0);
    // R7: a busy channel keeps its flush bit
    p_flush_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_reset |=> (($past(flush_q & dma_busy) & ~flush_q) == '0));
    // R6 / R10: finished flush leaves ready clear
    p_flush_clears_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|flush_done) |=> (($past(flush_done) & ready_q) == '0));
    // R9: re-prime drops ready for a cycle
    p_reprime_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|dma_reprime) |=> (($past(dma_reprime) & ready_q) == '0));
endmodule

// File: rtl/ep_buffer_ctrl.sv
module ep_buffer_ctrl
    import ep_buf_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic [NUM_CH-1:0] prime_sel,
    input  logic              prime_ack,
    input  logic [NUM_CH-1:0] dma_busy,
    input  logic [NUM_CH-1:0] dma_retire,
    input  logic [NUM_CH-1:0] dma_reprime
);
    ch_vec_t prime_set, flush_set, grant;
    ch_vec_t prime_q, flush_q, ready_q;

    ep_reg_decode #(.AW(AW), .DW(DW)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .prime_view (prime_q),
        .flush_view (flush_q),
        .ready_view (ready_q),
        .prime_set  (prime_set),
        .flush_set  (flush_set),
        .reg_rdata  (reg_rdata)
    );

    ep_prime_arb #(.EPS(NUM_EP)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (prime_q),
        .grant   (grant)
    );

    ep_ready_track u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_reset   (bus_reset),
        .prime_set   (prime_set),
        .flush_set   (flush_set),
        .grant       (grant),
        .prime_ack   (prime_ack),
        .dma_busy    (dma_busy),
        .dma_retire  (dma_retire),
        .dma_reprime (dma_reprime),
        .prime_q     (prime_q),
        .flush_q     (flush_q),
        .ready_q     (ready_q)
    );

    assign prime_sel = grant;
endmodule

// File: tb/ep_buffer_ctrl_test.sv
module ep_buffer_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_reset = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [11:0] prime_sel;
    logic        prime_ack = 1'b0;
    logic [11:0] dma_busy = '0;
    logic [11:0] dma_retire = '0;
    logic [11:0] dma_reprime = '0;

    int vectors = 0;
    int miscompares = 0;

    always #10 clk = ~clk;

    ep_buffer_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .prime_sel(prime_sel), .prime_ack(prime_ack),
        .dma_busy(dma_busy), .dma_retire(dma_retire), .dma_reprime(dma_reprime)
    );

    localparam logic [11:0] A_PRIME = 12'h1B0;
    localparam logic [11:0] A_FLUSH = 12'h1B4;
    localparam logic [11:0] A_READY = 12'h1B8;

    // {write addr, write data, read addr, expected read}; busy held high, no ack
    localparam logic [87:0] VEC [8] = '{
        {A_PRIME, 32'hFFC0_FFC0, A_PRIME, 32'h0000_0000},  // R2 reserved bits
        {A_PRIME, 32'h0001_0002, A_PRIME, 32'h0001_0002},  // R3 set tx0 rx1
        {A_PRIME, 32'h0000_0000, A_PRIME, 32'h0001_0002},  // R3 zero no effect
        {A_READY, 32'h003F_003F, A_READY, 32'h0000_0000},  // R12 ready read-only
        {A_FLUSH, 32'h0020_0001, A_FLUSH, 32'h0020_0001},  // R6 flush set
        {12'h1BC, 32'hFFFF_FFFF, 12'h1BC, 32'h0000_0000},  // R12 unmapped
        {A_FLUSH, 32'h0000_0000, A_FLUSH, 32'h0020_0001},  // R6 zero no effect
        {A_PRIME, 32'h0000_0000, A_READY, 32'h0000_0000}   // R5 nothing acked
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        prime_ack = 1'b1;
        @(negedge clk);
        prime_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata", reg_rdata, 32'h0);
        chk("R1 prime_sel", {20'h0, prime_sel}, 32'h0);
        rd(A_PRIME, v); chk("R1 prime", v, 32'h0);
        rd(A_FLUSH, v); chk("R1 flush", v, 32'h0);
        rd(A_READY, v); chk("R1 ready", v, 32'h0);

        dma_busy = 12'hFFF;
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][87:76], VEC[i][75:44]);
            rd(VEC[i][43:32], v);
            chk($sformatf("table %0d R2/R3/R6/R12", i), v, VEC[i][31:0]);
        end

        // R4: tx0 (bit 6) ahead of rx1 (bit 1)
        chk("R4 first grant", {20'h0, prime_sel}, 32'h040);
        ack_pulse();
        chk("R4 second grant", {20'h0, prime_sel}, 32'h002);
        rd(A_READY, v); chk("R5 tx0 ready", v, 32'h0001_0000);
        ack_pulse();
        rd(A_READY, v); chk("R5 rx1 ready", v, 32'h0001_0002);

        // R5: ack in the same cycle as the prime write does not count
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_PRIME; reg_wdata = 32'h0004_0000; prime_ack = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; prime_ack = 1'b0;
        rd(A_READY, v); chk("R5 not same cycle", v, 32'h0001_0002);
        rd(A_PRIME, v); chk("R3 still pending", v, 32'h0004_0000);
        ack_pulse();
        rd(A_READY, v); chk("R5 tx2 ready", v, 32'h0005_0002);

        // R7: flush held while busy
        wr(A_FLUSH, 32'h0001_0000);
        repeat (3) @(negedge clk);
        rd(A_FLUSH, v); chk("R7 flush held", v, 32'h0021_0001);
        rd(A_READY, v); chk("R7 ready held", v, 32'h0005_0002);

        // R6: release busy, flush completes
        @(negedge clk);
        dma_busy = 12'h000;
        rd(A_FLUSH, v); chk("R6 flush self-clear", v, 32'h0);
        rd(A_READY, v); chk("R6 ready cleared", v, 32'h0004_0002);

        // R10: flush completes with ack on rx4
        wr(A_PRIME, 32'h0000_0010);
        chk("R4 rx4 grant", {20'h0, prime_sel}, 32'h010);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_FLUSH; reg_wdata = 32'h0000_0010;
        @(negedge clk);
        reg_wr = 1'b0; prime_ack = 1'b1;
        @(negedge clk);
        prime_ack = 1'b0;
        rd(A_READY, v); chk("R10 flush wins", v, 32'h0004_0002);
        rd(A_PRIME, v); chk("R10 pending dropped", v, 32'h0);

        // R8: retire rx1
        @(negedge clk);
        dma_retire = 12'h002;
        @(negedge clk);
        dma_retire = 12'h000;
        rd(A_READY, v); chk("R8 retire", v, 32'h0004_0000);

        // R9: re-prime tx2 (bit 8)
        @(negedge clk);
        dma_reprime = 12'h100;
        @(negedge clk);
        dma_reprime = 12'h000; reg_rd = 1'b1; reg_addr = A_READY;
        @(negedge clk);
        chk("R9 drop", reg_rdata, 32'h0);
        @(negedge clk);
        chk("R9 restore", reg_rdata, 32'h0004_0000);
        reg_rd = 1'b0;
        @(negedge clk);
        chk("R12 idle rdata", reg_rdata, 32'h0);

        // R11: bus reset overrides everything
        dma_busy = 12'hFFF;
        wr(A_PRIME, 32'h0008_0000);
        wr(A_FLUSH, 32'h0008_0000);
        @(negedge clk);
        bus_reset = 1'b1; reg_wr = 1'b1; reg_addr = A_PRIME; reg_wdata = 32'h0000_0020;
        @(negedge clk);
        bus_reset = 1'b0; reg_wr = 1'b0;
        chk("R11 prime_sel", {20'h0, prime_sel}, 32'h0);
        rd(A_PRIME, v); chk("R11 prime", v, 32'h0);
        rd(A_FLUSH, v); chk("R11 flush", v, 32'h0);
        rd(A_READY, v); chk("R11 ready", v, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule